// File: doc/BRIEF.md
# Dual-Format Processor Timebase

This block keeps a 64-bit time value for a processor core and presents it as two 32-bit halves. Each half can be read and loaded on its own. A tick enable, made inside the block by dividing the core clock, advances the value. A mode strap selects how the count is formatted.

With the strap low, the two halves form one plain binary up-counter. With the strap high, the lower half counts nanoseconds and the upper half counts whole seconds. The lower half steps from the last nanosecond of a second to zero, and on that same edge the seconds half goes up by one.

Software loads a complete value in three steps. It first zeroes the lower half, then writes the upper half, then writes the lower half. Because the lower half is zero while the upper half is written, no carry can reach the new upper value. A reader samples upper, then lower, then upper again, and retries if the two upper samples differ.

Top module: `timebase_counter`

## Requirements
- R1: While reset is asserted and right after it is released, both halves read zero and the tick divider starts again from its first count.
- R2: A tick is produced once every TICK_DIV core clocks (default 8). After reset is released, the first tick falls on the 8th rising edge. The lower half goes up by exactly one on each tick edge and holds its value on every other edge.
- R3: With rtcMode = 0 (binary), the lower half goes from 0xFFFFFFFF to 0 on a tick, and the upper half goes up by one on that same edge. The upper half wraps from 0xFFFFFFFF to 0. In this mode the lower half passes 999,999,999 without any special action.
- R4: With rtcMode = 1 (seconds/nanoseconds), a tick with the lower half at 999,999,999 sets the lower half to 0 and adds one to the upper half on the same edge. A tick with the lower half above 999,999,999 does the same.
- R5: A write with wrHiEn = 1 places wrHiData in the upper half on the next rising edge. The lower half keeps counting as if no write had happened.
- R6: A write with wrLoEn = 1 places wrLoData in the lower half on the next rising edge. The upper half is left unchanged on that edge, and no carry is made on that edge.
- R7: On an edge that carries both a write and a tick, the written value wins for the half being written, including over a carry into the upper half. Counting picks up again on the next tick.
- R8: Take the load sequence lower := 0, then upper := H, then lower := L, on consecutive edges. It leaves exactly {H, L}, even when the lower half was at its wrap value and a tick falls on the first step.
- R9: Both halves are registered outputs that change only on rising edges. An upper/lower/upper read that spans a carry shows two different upper values, so it can be detected and retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcMode | input | 1 | Format strap: 0 binary, 1 seconds/nanoseconds |
| wrHiEn | input | 1 | Load strobe for the upper half |
| wrHiData | input | 32 | Value to load into the upper half |
| wrLoEn | input | 1 | Load strobe for the lower half |
| wrLoData | input | 32 | Value to load into the lower half |
| hiOut | output | 32 | Upper half (seconds in RTC format) |
| loOut | output | 32 | Lower half (nanoseconds in RTC format) |

## Verification
A write shows on the outputs one rising edge after its strobe. An increment shows on the edge where the divider reaches its last count, which is edge 8, 16, 24 and so on after reset is released. Every scenario therefore starts from a fresh reset, so the tick phase is known. The expected value of each vector is the written value plus floor((wait + 1) / 8) ticks, with the carry applied by hand. Inputs change and outputs are sampled on falling edges, half a cycle after the edge that the result belongs to. The directed cases place a write on edge 8 on purpose, so that it collides with a tick.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  typedef struct packed {
    logic tick;     // divider tick this cycle
    logic loadHi;   // upper half takes write data
    logic loadLo;   // lower half takes write data
    logic stepLo;   // lower half advances
    logic stepHi;   // upper half advances by carry
  } tbcStrobes_t;

endpackage

// File: rtl/tbc_tick_div.sv
module tbc_tick_div #(
  parameter int TICK_DIV = 8
) (
  input  logic clk,
  input  logic rstN,
  output logic tickEn
);

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tickEn = 1'b1;
    end else begin : g_div
      localparam int CNT_W = $clog2(TICK_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
      logic [CNT_W-1:0] divCnt;

      assign tickEn = (divCnt == LAST);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       divCnt <= '0;
        else if (tickEn) divCnt <= '0;
        else             divCnt <= divCnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
(
  input  logic        tickEn,
  input  logic        wrHiEn,
  input  logic        wrLoEn,
  input  logic        loAtEnd,
  output tbcStrobes_t strb
);

  always_comb begin
    strb.tick   = tickEn;
    strb.loadHi = wrHiEn;
    strb.loadLo = wrLoEn;
    // a write to the lower half replaces its increment, so no carry is born
    strb.stepLo = tickEn & ~wrLoEn;
    // carry into the upper half yields to a write of the upper half
    strb.stepHi = tickEn & ~wrLoEn & loAtEnd & ~wrHiEn;
  end

endmodule

// File: rtl/tbc_datapath.sv
module tbc_datapath
  import tbc_pkg::*;
#(
  parameter int HALF_W     = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcMode,
  input  tbcStrobes_t       strb,
  input  logic [HALF_W-1:0] wrHiData,
  input  logic [HALF_W-1:0] wrLoData,
  output logic [HALF_W-1:0] hiQ,
  output logic [HALF_W-1:0] loQ,
  output logic              loAtEnd
);

  localparam logic [HALF_W-1:0] NS_TOP = HALF_W'(NS_PER_SEC - 1);

  // out-of-range nanosecond values also wrap, keeping the field recoverable
  assign loAtEnd = rtcMode ? (loQ >= NS_TOP) : (&loQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ <= '0;
    end else if (strb.loadLo) begin
      loQ <= wrLoData;
    end else if (strb.stepLo) begin
      loQ <= loAtEnd ? '0 : loQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
    end else if (strb.loadHi) begin
      hiQ <= wrHiData;
    end else if (strb.stepHi) begin
      hiQ <= hiQ + 1'b1;
    end
  end

endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
  import tbc_pkg::*;
#(
  parameter int HALF_W     = 32,
  parameter int TICK_DIV   = 8,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcMode,
  input  logic              wrHiEn,
  input  logic [HALF_W-1:0] wrHiData,
  input  logic              wrLoEn,
  input  logic [HALF_W-1:0] wrLoData,
  output logic [HALF_W-1:0] hiOut,
  output logic [HALF_W-1:0] loOut
);

  logic        tickEn;
  logic        loAtEnd;
  tbcStrobes_t strb;

  tbc_tick_div #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn)
  );

  tbc_ctrl ctrl_i (
    .tickEn  (tickEn),
    .wrHiEn  (wrHiEn),
    .wrLoEn  (wrLoEn),
    .loAtEnd (loAtEnd),
    .strb    (strb)
  );

  tbc_datapath #(.HALF_W(HALF_W), .NS_PER_SEC(NS_PER_SEC)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rtcMode  (rtcMode),
    .strb     (strb),
    .wrHiData (wrHiData),
    .wrLoData (wrLoData),
    .hiQ      (hiOut),
    .loQ      (loOut),
    .loAtEnd  (loAtEnd)
  );

endmodule

// File: rtl/timebase_counter_chk.sv
module timebase_counter_chk #(
  parameter int HALF_W     = 32,
  parameter int TICK_DIV   = 8,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              rtcMode,
  input logic              wrHiEn,
  input logic [HALF_W-1:0] wrHiData,
  input logic              wrLoEn,
  input logic [HALF_W-1:0] wrLoData,
  input logic [HALF_W-1:0] hiOut,
  input logic [HALF_W-1:0] loOut,
  input logic              tickEn
);

  localparam logic [HALF_W-1:0] NS_TOP = HALF_W'(NS_PER_SEC - 1);
  localparam logic [HALF_W-1:0] ALL1   = '1;
  localparam logic [HALF_W-1:0] ONE    = HALF_W'(1);

  a_r2_hold_lo: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrLoEn) |=> $stable(loOut));

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    (TICK_DIV > 1 && tickEn) |=> !tickEn);

  a_r3_bin_carry: assert property (@(posedge clk) disable iff (!rstN)
    (!rtcMode && tickEn && !wrLoEn && !wrHiEn && loOut == ALL1)
      |=> (loOut == '0 && hiOut == $past(hiOut) + ONE));

  a_r4_rtc_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rtcMode && tickEn && !wrLoEn && !wrHiEn && loOut >= NS_TOP)
      |=> (loOut == '0 && hiOut == $past(hiOut) + ONE));

  a_r5_hi_load: assert property (@(posedge clk) disable iff (!rstN)
    wrHiEn |=> hiOut == $past(wrHiData));

  a_r6_lo_load: assert property (@(posedge clk) disable iff (!rstN)
    wrLoEn |=> loOut == $past(wrLoData));

  a_r6_no_carry_on_lo_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrLoEn && !wrHiEn) |=> $stable(hiOut));

endmodule

bind timebase_counter timebase_counter_chk #(
  .HALF_W(HALF_W), .TICK_DIV(TICK_DIV), .NS_PER_SEC(NS_PER_SEC)
) chk_i (
  .clk(clk), .rstN(rstN), .rtcMode(rtcMode),
  .wrHiEn(wrHiEn), .wrHiData(wrHiData),
  .wrLoEn(wrLoEn), .wrLoData(wrLoData),
  .hiOut(hiOut), .loOut(loOut), .tickEn(tickEn)
);

// File: tb/timebase_counter_tb_top.sv
`timescale 1ns/1ps
module timebase_counter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        rtcMode = 1'b0;
  logic        wrHiEn = 1'b0;
  logic [31:0] wrHiData = '0;
  logic        wrLoEn = 1'b0;
  logic [31:0] wrLoData = '0;
  logic [31:0] hiOut, loOut;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  timebase_counter dut_i (
    .clk(clk), .rstN(rstN), .rtcMode(rtcMode),
    .wrHiEn(wrHiEn), .wrHiData(wrHiData),
    .wrLoEn(wrLoEn), .wrLoData(wrLoData),
    .hiOut(hiOut), .loOut(loOut)
  );

  typedef struct packed {
    logic        rtc;
    logic        doHi;
    logic [31:0] hiVal;
    logic        doLo;
    logic [31:0] loVal;
    logic [7:0]  waitCyc;
    logic [31:0] expHi;
    logic [31:0] expLo;
    logic [3:0]  req;
  } vec_t;

  // expected lower = written + floor((waitCyc + 1) / 8) ticks, carry applied
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b1, 32'd5,        1'b1, 32'hFFFF_FFF0, 8'd135, 32'd6, 32'd1,          4'd3}, // R3
    '{1'b1, 1'b1, 32'd7,        1'b1, 32'd999999990, 8'd95,  32'd8, 32'd2,          4'd4}, // R4
    '{1'b1, 1'b1, 32'd0,        1'b1, 32'd1200000000,8'd7,   32'd1, 32'd0,          4'd4}, // R4 above range
    '{1'b0, 1'b1, 32'd0,        1'b1, 32'd1200000000,8'd7,   32'd0, 32'd1200000001, 4'd3}, // R3 no ns wrap
    '{1'b0, 1'b1, 32'h0000_ABCD,1'b0, 32'd0,         8'd15,  32'h0000_ABCD, 32'd2,  4'd5}, // R5
    '{1'b0, 1'b0, 32'd0,        1'b1, 32'h100,       8'd23,  32'd0, 32'h103,        4'd6}, // R6
    '{1'b1, 1'b1, 32'hFFFF_FFFF,1'b1, 32'd999999999, 8'd7,   32'd0, 32'd0,          4'd4}, // R4 seconds wrap
    '{1'b0, 1'b1, 32'hFFFF_FFFF,1'b1, 32'hFFFF_FFFF, 8'd7,   32'd0, 32'd0,          4'd3}, // R3 full wrap
    '{1'b1, 1'b1, 32'd3,        1'b1, 32'd500,       8'd6,   32'd3, 32'd500,        4'd2}  // R2 no tick yet
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // leaves the bench at the falling edge right after reset release
  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    wrHiEn = 1'b0;
    wrLoEn = 1'b0;
    cyc(2);
    rstN = 1'b1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int retries;
    logic [31:0] h1, h2, lo;

    #1 rstN = 1'b0;
    // R1: state during and just after reset
    cyc(2);
    chk("R1 hi in reset", hiOut, 32'd0);
    chk("R1 lo in reset", loOut, 32'd0);
    rstN = 1'b1;
    chk("R1 hi after release", hiOut, 32'd0);

    // R2: first tick on edge 8
    cyc(7);
    chk("R2 lo before first tick", loOut, 32'd0);
    cyc(1);
    chk("R2 lo after first tick", loOut, 32'd1);
    cyc(8);
    chk("R2 lo after second tick", loOut, 32'd2);

    // vector table
    foreach (VECS[i]) begin
      doReset();
      rtcMode  = VECS[i].rtc;
      wrHiEn   = VECS[i].doHi;
      wrHiData = VECS[i].hiVal;
      wrLoEn   = VECS[i].doLo;
      wrLoData = VECS[i].loVal;
      cyc(1);
      wrHiEn = 1'b0;
      wrLoEn = 1'b0;
      cyc(int'(VECS[i].waitCyc));
      chk($sformatf("R%0d vec %0d hi", VECS[i].req, i), hiOut, VECS[i].expHi);
      chk($sformatf("R%0d vec %0d lo", VECS[i].req, i), loOut, VECS[i].expLo);
    end

    // R7: upper write lands on a carrying tick; write wins
    doReset();
    rtcMode = 1'b0;
    wrHiEn = 1'b1; wrHiData = 32'd0; wrLoEn = 1'b1; wrLoData = 32'hFFFF_FFFF;
    cyc(1);
    wrHiEn = 1'b0; wrLoEn = 1'b0;
    cyc(6);
    wrHiEn = 1'b1; wrHiData = 32'h50;
    cyc(1);
    wrHiEn = 1'b0;
    chk("R7 hi write over carry", hiOut, 32'h50);
    chk("R7 lo wrapped on same tick", loOut, 32'd0);
    cyc(8);
    chk("R7 lo resumes", loOut, 32'd1);
    chk("R7 hi held", hiOut, 32'h50);

    // R7: lower write lands on a tick; written value exact, then resumes
    doReset();
    cyc(7);
    wrLoEn = 1'b1; wrLoData = 32'h40;
    cyc(1);
    wrLoEn = 1'b0;
    chk("R7 lo write over tick", loOut, 32'h40);
    cyc(7);
    chk("R7 lo held between ticks", loOut, 32'h40);
    cyc(1);
    chk("R7 lo next tick", loOut, 32'h41);

    // R8: safe load sequence starting from a value about to carry
    doReset();
    rtcMode = 1'b0;
    wrHiEn = 1'b1; wrHiData = 32'd3; wrLoEn = 1'b1; wrLoData = 32'hFFFF_FFFF;
    cyc(1);
    wrHiEn = 1'b0; wrLoEn = 1'b0;
    cyc(6);
    wrLoEn = 1'b1; wrLoData = 32'd0;
    cyc(1);
    chk("R8 step1 hi untouched", hiOut, 32'd3);
    chk("R8 step1 lo cleared", loOut, 32'd0);
    wrLoEn = 1'b0; wrHiEn = 1'b1; wrHiData = 32'h1234;
    cyc(1);
    wrHiEn = 1'b0; wrLoEn = 1'b1; wrLoData = 32'h5678;
    cyc(1);
    wrLoEn = 1'b0;
    chk("R8 final hi", hiOut, 32'h1234);
    chk("R8 final lo", loOut, 32'h5678);

    // R9: torn read across a carry, then retry
    doReset();
    wrHiEn = 1'b1; wrHiData = 32'd9; wrLoEn = 1'b1; wrLoData = 32'hFFFF_FFFF;
    cyc(1);
    wrHiEn = 1'b0; wrLoEn = 1'b0;
    h1 = hiOut;
    cyc(8);
    lo = loOut;
    cyc(1);
    h2 = hiOut;
    chk("R9 torn read detected", 32'(h1 != h2), 32'd1);
    retries = 0;
    do begin
      cyc(1); h1 = hiOut;
      cyc(1); lo = loOut;
      cyc(1); h2 = hiOut;
      retries++;
    end while (h1 != h2 && retries < 4);
    chk("R9 retry hi", h2, 32'd10);
    chk("R9 retry lo", lo, 32'd0);

    summary();
    $finish;
  end

endmodule